// File: doc/BRIEF.md
# Masked Unsigned-to-Double Vector Converter

This block turns packed unsigned 32-bit integers into IEEE-754 double-precision values and writes them into a 512-bit destination vector. A two-bit length code picks how many lanes take part. Each active lane converts either its own source element or one shared scalar (broadcast). A per-lane write mask, together with a merge or zero policy, decides what a masked-off lane holds. Every destination bit above the active length is cleared.

A 4-bit reserved field is checked on every request. Any value other than all ones marks the request illegal, and the destination is then passed through unchanged. The conversion is always exact, so there is no rounding and no exception state.

A request is presented with `in_valid`. The result is registered and appears together with `out_valid` one clock later.

Top module: `vec_u2d_cvt`

## Requirements
- R1: The length code `vlen_sel` enables 2 lanes for 2'b00, 4 lanes for 2'b01 and 8 lanes for 2'b10 or 2'b11. Lane j reads `src[32j+31:32j]` and writes `out_dst[64j+63:64j]`.
- R2: A nonzero input converts to a double with sign 0, a biased exponent of 1023 plus the position of its highest set bit, and a fraction made of the bits below that set bit, left-aligned in 52 bits and padded with zeros. An input of zero gives the all-zero 64-bit pattern.
- R3: When `bcast_en` is 1, every active lane converts `src[31:0]` in place of its own element.
- R4: An active lane converts when `mask_en` is 0 or when its bit in `mask` is 1.
- R5: An active lane whose mask bit is 0, with `mask_en` 1 and `zero_mode` 0, outputs the matching 64 bits of `old_dst`.
- R6: An active lane whose mask bit is 0, with `mask_en` 1 and `zero_mode` 1, outputs zero.
- R7: All destination bits from the active length up to bit 511 are zero, whatever the mask and the masking policy.
- R8: When `rsv_field` is not 4'b1111, `out_illegal` is 1 and `out_dst` equals `old_dst` of that request.
- R9: `out_valid` rises one cycle after an accepted request, and `out_dst` and `out_illegal` are updated in that same cycle. In a cycle with no request, `out_valid` and `out_illegal` become 0 and `out_dst` keeps its value.
- R10: After reset, `out_valid`, `out_illegal` and `out_dst` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| vlen_sel | input | 2 | Vector length code |
| src | input | 256 | Packed unsigned 32-bit source elements |
| bcast_en | input | 1 | Use `src[31:0]` for all active lanes |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1: clear masked lanes, 0: keep old value |
| old_dst | input | 512 | Previous destination value |
| rsv_field | input | 4 | Reserved encoding field, must be all ones |
| out_valid | output | 1 | Result valid |
| out_dst | output | 512 | New destination vector |
| out_illegal | output | 1 | Reserved field was not all ones |

## Verification
The converter is tried with integer edge values: zero, one, powers of two, all ones and values with only the top bit set. These separate mistakes in the exponent offset, the fraction alignment and the zero special case. Each length code is applied with a nonzero upper source and a nonzero `old_dst`, so that a missing clear above the active length shows up. Mask patterns under merge and under zero policy are applied on identical data, which tells the two policies apart. Broadcast runs with distinct per-lane elements, so that a lane reading its own element stands out. Illegal reserved values and idle cycles confirm that the destination passes through or holds. Long randomised runs then mix all of these cases.

// File: rtl/u2d_pkg.sv
package u2d_pkg;
   localparam int DP_W   = 64;
   localparam int EXP_W  = 11;
   localparam int FRAC_W = 52;
   localparam int BIAS   = 1023;

   typedef enum logic [1:0] {
      VL_QUARTER = 2'b00,
      VL_HALF    = 2'b01,
      VL_FULL    = 2'b10,
      VL_FULL_B  = 2'b11
   } vlen_e;
endpackage

// File: rtl/u2d_lead_one.sv
module u2d_lead_one #(
   parameter int W = 32
) (
   input  logic [W-1:0]         val,
   output logic [$clog2(W)-1:0] pos,
   output logic                 found
);
   localparam int PW = $clog2(W);

   if (W < 2) begin : g_bad_w
      $error("u2d_lead_one: W must be at least 2");
   end

   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (val[i]) pos = PW'(i);
      end
      found = |val;
   end
endmodule

// File: rtl/u2d_lane_cvt.sv
module u2d_lane_cvt
   import u2d_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic [INT_W-1:0] val,
   output logic [DP_W-1:0]  dp
);
   localparam int PW  = $clog2(INT_W);
   localparam int PAD = FRAC_W - (INT_W - 1);

   if (INT_W > FRAC_W + 1) begin : g_bad_w
      $error("u2d_lane_cvt: INT_W too wide for an exact double");
   end

   logic [PW-1:0]    lead_pos;
   logic             nonzero;
   logic [INT_W-1:0] aligned;
   logic [EXP_W-1:0] exp_f;
   logic [FRAC_W-1:0] frac_f;

   u2d_lead_one #(.W(INT_W)) u_lead (
      .val   (val),
      .pos   (lead_pos),
      .found (nonzero)
   );

   always_comb begin
      aligned = val << (PW'(INT_W - 1) - lead_pos);
      exp_f   = EXP_W'(BIAS) + EXP_W'(lead_pos);
      if (PAD > 0) frac_f = {aligned[INT_W-2:0], {PAD{1'b0}}};
      else         frac_f = FRAC_W'(aligned[INT_W-2:0]);
      dp      = nonzero ? {1'b0, exp_f, frac_f} : '0;
   end
endmodule

// File: rtl/u2d_lane_sel.sv
module u2d_lane_sel
   import u2d_pkg::*;
(
   input  logic            active,
   input  logic            take,
   input  logic            zero_mode,
   input  logic [DP_W-1:0] cvt,
   input  logic [DP_W-1:0] old,
   output logic [DP_W-1:0] res
);
   always_comb begin
      if (!active)        res = '0;
      else if (take)      res = cvt;
      else if (zero_mode) res = '0;
      else                res = old;
   end
endmodule

// File: rtl/vec_u2d_cvt.sv
module vec_u2d_cvt
   import u2d_pkg::*;
#(
   parameter int LANES = 8,
   parameter int INT_W = 32,
   parameter int RSV_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [1:0]             vlen_sel,
   input  logic [LANES*INT_W-1:0] src,
   input  logic                   bcast_en,
   input  logic [LANES-1:0]       mask,
   input  logic                   mask_en,
   input  logic                   zero_mode,
   input  logic [LANES*DP_W-1:0]  old_dst,
   input  logic [RSV_W-1:0]       rsv_field,
   output logic                   out_valid,
   output logic [LANES*DP_W-1:0]  out_dst,
   output logic                   out_illegal
);
   localparam int DST_W   = LANES * DP_W;
   localparam int Q_LANES = LANES / 4;
   localparam int H_LANES = LANES / 2;

   if (LANES < 4 || (LANES % 4) != 0) begin : g_bad_lanes
      $error("vec_u2d_cvt: LANES must be a multiple of 4");
   end

   logic [DST_W-1:0] lane_res;
   logic             legal;
   vlen_e            vl;

   assign vl    = vlen_e'(vlen_sel);
   assign legal = (rsv_field == {RSV_W{1'b1}});

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [INT_W-1:0] elem;
      logic [DP_W-1:0]  cvt;
      logic             active;

      assign elem = bcast_en ? src[INT_W-1:0] : src[j*INT_W +: INT_W];

      if (j < Q_LANES) begin : g_q
         assign active = 1'b1;
      end else if (j < H_LANES) begin : g_h
         assign active = (vl != VL_QUARTER);
      end else begin : g_f
         assign active = (vl == VL_FULL) || (vl == VL_FULL_B);
      end

      u2d_lane_cvt #(.INT_W(INT_W)) u_cvt (
         .val (elem),
         .dp  (cvt)
      );

      u2d_lane_sel u_sel (
         .active    (active),
         .take      (~mask_en | mask[j]),
         .zero_mode (zero_mode),
         .cvt       (cvt),
         .old       (old_dst[j*DP_W +: DP_W]),
         .res       (lane_res[j*DP_W +: DP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_dst     <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & ~legal;
         if (in_valid) out_dst <= legal ? lane_res : old_dst;
      end
   end
endmodule

// File: rtl/u2d_cvt_chk.sv
module u2d_cvt_chk
   import u2d_pkg::*;
#(
   parameter int LANES = 8,
   parameter int INT_W = 32,
   parameter int RSV_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [1:0]             vlen_sel,
   input logic [LANES*INT_W-1:0] src,
   input logic                   bcast_en,
   input logic [LANES-1:0]       mask,
   input logic                   mask_en,
   input logic                   zero_mode,
   input logic [LANES*DP_W-1:0]  old_dst,
   input logic [RSV_W-1:0]       rsv_field,
   input logic                   out_valid,
   input logic [LANES*DP_W-1:0]  out_dst,
   input logic                   out_illegal
);
   localparam int DST_W = LANES * DP_W;
   logic ok_req;
   assign ok_req = in_valid && (rsv_field == {RSV_W{1'b1}});

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && $stable(out_dst)));
   assert_illegal_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rsv_field != {RSV_W{1'b1}}) |=> (out_illegal && out_dst == $past(old_dst)));
   assert_quarter_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && vlen_sel == 2'b00) |=> (out_dst[DST_W-1:DST_W/4] == '0));
   assert_half_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && vlen_sel == 2'b01) |=> (out_dst[DST_W-1:DST_W/2] == '0));
   assert_merge_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && mask_en && !mask[0] && !zero_mode) |=> (out_dst[DP_W-1:0] == $past(old_dst[DP_W-1:0])));
   assert_zero_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && mask_en && !mask[0] && zero_mode) |=> (out_dst[DP_W-1:0] == '0));
   assert_zero_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && (!mask_en || mask[0]) && src[INT_W-1:0] == '0) |=> (out_dst[DP_W-1:0] == '0));
   assert_sign_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && (!mask_en || mask[0])) |=> !out_dst[DP_W-1]);
   assert_bcast_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_req && bcast_en && !mask_en && vlen_sel == 2'b01) |=> (out_dst[2*DP_W-1:DP_W] == out_dst[DP_W-1:0]));
endmodule

bind vec_u2d_cvt u2d_cvt_chk #(.LANES(LANES), .INT_W(INT_W), .RSV_W(RSV_W)) u_chk (.*);

// File: tb/vec_u2d_cvt_bench.sv
`timescale 1ns/1ps
module vec_u2d_cvt_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   vlen_sel = '0;
   logic [255:0] src = '0;
   logic         bcast_en = 1'b0;
   logic [7:0]   mask = '0;
   logic         mask_en = 1'b0;
   logic         zero_mode = 1'b0;
   logic [511:0] old_dst = '0;
   logic [3:0]   rsv_field = 4'hF;
   logic         out_valid;
   logic [511:0] out_dst;
   logic         out_illegal;

   int n_cmp = 0;
   int n_bad = 0;
   logic         exp_valid = 1'b0;
   logic         exp_ill = 1'b0;
   logic [511:0] exp_dst = '0;

   always #2 clk = ~clk;

   vec_u2d_cvt u_vec_u2d_cvt (.*);

   function automatic logic [63:0] to_dp(logic [31:0] v);
      real r;
      r = real'(longint'({32'b0, v}));
      return $realtobits(r);
   endfunction

   function automatic logic [511:0] model_dst();
      logic [511:0] d;
      int nl;
      d = '0;
      nl = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8;
      if (rsv_field != 4'hF) return old_dst;
      for (int j = 0; j < 8; j++) begin
         if (j < nl) begin
            if (!mask_en || mask[j])
               d[j*64 +: 64] = to_dp(bcast_en ? src[31:0] : src[j*32 +: 32]);
            else if (!zero_mode)
               d[j*64 +: 64] = old_dst[j*64 +: 64];
         end
      end
      return d;
   endfunction

   task automatic compare(string req);
      n_cmp++;
      if (out_valid !== exp_valid || out_illegal !== exp_ill || out_dst !== exp_dst) begin
         n_bad++;
         $display("FAIL %s: got v=%b ill=%b dst=%h exp v=%b ill=%b dst=%h",
                  req, out_valid, out_illegal, out_dst, exp_valid, exp_ill, exp_dst);
      end
   endtask

   // drive a request (or idle) at a negedge, check one cycle later
   task automatic step(bit v, string req);
      logic [511:0] nd;
      in_valid = v;
      nd = v ? model_dst() : exp_dst;
      @(negedge clk);
      exp_valid = v;
      exp_ill   = v && (rsv_field != 4'hF);
      exp_dst   = nd;
      compare(req);
   endtask

   task automatic req(logic [1:0] vl, logic [255:0] s, bit bc, logic [7:0] m,
                      bit me, bit zm, logic [511:0] od, logic [3:0] rsv, string tag);
      vlen_sel = vl; src = s; bcast_en = bc; mask = m; mask_en = me;
      zero_mode = zm; old_dst = od; rsv_field = rsv;
      step(1'b1, tag);
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [255:0] edge_src;
      logic [511:0] ones;
      ones = '1;
      edge_src = {32'h8000_0001, 32'h0001_0000, 32'h7FFF_FFFF, 32'h0000_0002,
                  32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000};
      repeat (3) @(negedge clk);
      compare("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10 after release");

      req(2'b10, edge_src, 0, 8'h00, 0, 0, ones, 4'hF, "R1 R2 full edges");
      req(2'b11, ~edge_src, 0, 8'h00, 0, 0, '0, 4'hF, "R1 alt full code");
      req(2'b00, edge_src, 0, 8'hFF, 1, 0, ones, 4'hF, "R7 quarter clear");
      req(2'b01, edge_src, 0, 8'hFF, 1, 1, ones, 4'hF, "R7 half clear");
      req(2'b10, edge_src, 0, 8'h5A, 1, 0, ones, 4'hF, "R4 R5 merge");
      req(2'b10, edge_src, 0, 8'h5A, 1, 1, ones, 4'hF, "R4 R6 zero");
      req(2'b10, edge_src | 256'h1234_5678, 1, 8'h00, 0, 0, ones, 4'hF, "R3 broadcast");
      req(2'b01, edge_src, 1, 8'h06, 1, 0, ones, 4'hF, "R3 R5 broadcast merge");
      req(2'b00, edge_src, 0, 8'h00, 1, 0, ones, 4'hF, "R7 masked quarter");
      req(2'b10, edge_src, 0, 8'hFF, 0, 0, {8{64'hDEAD_BEEF_0BAD_F00D}}, 4'hE, "R8 illegal");
      req(2'b00, edge_src, 0, 8'hFF, 0, 1, ones, 4'h0, "R8 illegal zero field");
      step(1'b0, "R9 idle hold");
      step(1'b0, "R9 idle hold 2");
      req(2'b10, {8{32'h0000_0000}}, 0, 8'h00, 0, 0, ones, 4'hF, "R2 all zero");

      for (int k = 0; k < 400; k++) begin
         logic [255:0] rs;
         logic [511:0] ro;
         for (int w = 0; w < 8; w++) rs[w*32 +: 32] = $urandom >> ($urandom % 32);
         for (int w = 0; w < 16; w++) ro[w*32 +: 32] = $urandom;
         if (($urandom % 5) == 0) step(1'b0, "R9 random idle");
         else req(2'($urandom), rs, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  ro, (($urandom % 6) == 0) ? 4'($urandom) : 4'hF, "R1 R2 random");
      end

      rst_n = 1'b0;
      #1;
      exp_valid = 1'b0; exp_ill = 1'b0; exp_dst = '0;
      compare("R10 mid-run reset");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule